// File: doc/BRIEF.md
# Two-Wire Codec Register Write Master

This block is a write-only master for a two-wire serial control bus. It loads one 16-bit configuration word into an audio codec. A single write-enable strobe latches the word and starts the transfer. The transfer is a start condition, then three bytes, then a stop condition. The three bytes are the fixed device address with the write bit, the upper half of the word and the lower half of the word. The word holds a 7-bit register address in bits [15:9] and 9 bits of register data in bits [8:0], so the register address and the top data bit travel together in the upper byte. A typical word is 16'h080D, which writes data 000001101 to register 0000100.

The clock line is driven push-pull. The data line is open-drain: the block only ever pulls it low. The data line is read back through a separate input, and on the ninth clock of every byte the block samples the acknowledge from that input. Each byte records its own acknowledge flag. A byte that is not acknowledged ends the transfer at once with a stop condition. The bit period is a fixed division of the system clock. Each bit slot is split into four equal quarters. The clock line is low for the first two quarters and high for the last two. The data line changes at the start of the second quarter and is sampled at the start of the fourth.

Top module: `i2c_codec_writer`

## Requirements
- R1: During reset and while idle, `scl_o` is 1, `sda_pull_o` is 0, `busy_o` is 0 and `done_o` is 0. Reset also clears `ack_o` to 0.
- R2: One bit slot lasts 4*QTR_CYCLES system clocks, which is 128 at the default of 32. The clock line is low for the first 2*QTR_CYCLES clocks of a slot and high for the rest. The transfer opens with a start slot in which the clock line stays high and the data line falls halfway through.
- R3: The bytes are sent MSB first in this order: 8'h34 (device address 0011010 followed by write bit 0), then `word_i[15:8]`, then `word_i[7:0]`. Each byte is followed by a ninth slot in which the data line is released.
- R4: Outside the start and stop slots, `sda_pull_o` changes only while `scl_o` is low, at the start of the second quarter of a slot.
- R5: `sda_i` is sampled at the start of the fourth quarter of each ninth slot, where 0 means acknowledge. `ack_o[0]`, `ack_o[1]` and `ack_o[2]` record the acknowledge of the address byte, the upper byte and the lower byte, each 1 when acknowledged.
- R6: If a byte is not acknowledged, the stop slot follows that byte's ninth slot directly and no further byte is sent.
- R7: The stop slot drives the clock line low, then pulls data low, then raises the clock line, then releases data while the clock line is high. On the clock after the stop slot the block is idle and `done_o` is 1 for exactly one cycle.
- R8: `wr_en_i` and `word_i` are ignored while `busy_o` is 1. The transfer in progress is not altered and no new transfer follows it.
- R9: When a transfer is accepted, all three acknowledge flags clear to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Starts a transfer when the block is idle |
| word_i | input | 16 | Register address [15:9] and register data [8:0], latched on start |
| sda_i | input | 1 | Level read back from the data line |
| scl_o | output | 1 | Bus clock line |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| ack_o | output | 3 | Per-byte acknowledge flags (bit 0 address, bit 1 upper, bit 2 lower) |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse after the stop slot |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- A refused acknowledge on each of the three bytes. A design that sampled the acknowledge at the wrong quarter, or ignored it, would keep clocking out bytes instead of entering the stop slot.
- Transfers whose previous result left acknowledge flags set. A design that failed to clear the flags would show stale bits early in the next transfer.
- A second strobe with a different word in the middle of a transfer. A design that accepted it would corrupt the data-line pattern or start a second frame after the first.
- A reset in the middle of a transfer, which must leave both lines released at once.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    // Default quarter length: 4 quarters of 32 clocks = one bit slot of 128 clocks
    localparam int unsigned QTR_CYCLES_DEF = 32;
    localparam int unsigned WORD_W         = 16;
    localparam int unsigned BYTES_PER_XFER = 3;
    localparam int unsigned SLOT_BITS      = 9;   // 8 data + 1 acknowledge
    localparam logic [6:0]  CODEC_DEV_ADDR = 7'b0011010;
    localparam logic        DIR_WRITE      = 1'b0;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_BIT   = 2'd2,
        PH_STOP  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [1:0] quarter;   // position inside the current bit slot
        logic [1:0] byte_idx;  // 0 address, 1 upper, 2 lower
        logic [3:0] bit_idx;   // 0..7 data bits, 8 acknowledge slot
    } slot_pos_t;

    // Byte put on the wire for a given position in the frame
    function automatic logic [7:0] frame_byte(input logic [WORD_W-1:0] w,
                                              input logic [1:0] idx);
        logic [7:0] b;
        case (idx)
            2'd0:    b = {CODEC_DEV_ADDR, DIR_WRITE};
            2'd1:    b = w[15:8];
            default: b = w[7:0];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/i2cw_quarter_timer.sv
module i2cw_quarter_timer #(
    parameter int unsigned QTR_CYCLES = i2cw_pkg::QTR_CYCLES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic qtick
);
    localparam int unsigned CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qtick = run && (cnt_q == LAST);

    generate
        if (QTR_CYCLES > 1) begin : g_gap_check
            // R2: quarter boundaries are spaced, never back to back
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                qtick |=> !qtick);
        end
    endgenerate

endmodule

// File: rtl/i2cw_frame_seq.sv
module i2cw_frame_seq
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              qtick,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              sda_i,
    output logic              run,
    output logic              scl_o,
    output logic              sda_pull_o,
    output logic [2:0]        ack_o,
    output logic              done_o
);
    phase_e            ph_q;
    slot_pos_t         pos_q;
    logic [WORD_W-1:0] word_q;
    logic              scl_q;
    logic              pull_q;
    logic [2:0]        ack_q;
    logic              done_q;

    logic [1:0] nq;
    logic [7:0] cur_byte;
    logic       tx_bit;
    logic       ack_sel;
    logic       last_byte;

    always_comb begin
        nq        = pos_q.quarter + 2'd1;
        cur_byte  = frame_byte(word_q, pos_q.byte_idx);
        tx_bit    = (pos_q.bit_idx == 4'd8) ? 1'b1 : cur_byte[3'd7 - pos_q.bit_idx[2:0]];
        last_byte = (pos_q.byte_idx == 2'd2);
        case (pos_q.byte_idx)
            2'd0:    ack_sel = ack_q[0];
            2'd1:    ack_sel = ack_q[1];
            default: ack_sel = ack_q[2];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            pos_q  <= '0;
            word_q <= '0;
            scl_q  <= 1'b1;
            pull_q <= 1'b0;
            ack_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ph_q == PH_IDLE) begin
                scl_q  <= 1'b1;
                pull_q <= 1'b0;
                if (wr_en_i) begin
                    word_q <= word_i;
                    ack_q  <= '0;
                    pos_q  <= '0;
                    ph_q   <= PH_START;
                end
            end else if (qtick) begin
                pos_q.quarter <= nq;
                unique case (ph_q)
                    PH_START: begin
                        if (nq == 2'd2) pull_q <= 1'b1;
                        if (nq == 2'd0) begin
                            scl_q          <= 1'b0;
                            ph_q           <= PH_BIT;
                            pos_q.byte_idx <= 2'd0;
                            pos_q.bit_idx  <= 4'd0;
                        end
                    end
                    PH_BIT: begin
                        case (nq)
                            2'd1: pull_q <= !tx_bit;
                            2'd2: scl_q  <= 1'b1;
                            2'd3: begin
                                if (pos_q.bit_idx == 4'd8) begin
                                    case (pos_q.byte_idx)
                                        2'd0:    ack_q[0] <= !sda_i;
                                        2'd1:    ack_q[1] <= !sda_i;
                                        default: ack_q[2] <= !sda_i;
                                    endcase
                                end
                            end
                            default: begin
                                scl_q <= 1'b0;
                                if (pos_q.bit_idx != 4'd8) begin
                                    pos_q.bit_idx <= pos_q.bit_idx + 4'd1;
                                end else if (ack_sel && !last_byte) begin
                                    pos_q.byte_idx <= pos_q.byte_idx + 2'd1;
                                    pos_q.bit_idx  <= 4'd0;
                                end else begin
                                    ph_q <= PH_STOP;
                                end
                            end
                        endcase
                    end
                    PH_STOP: begin
                        case (nq)
                            2'd1:    pull_q <= 1'b1;
                            2'd2:    scl_q  <= 1'b1;
                            2'd3:    pull_q <= 1'b0;
                            default: begin
                                ph_q   <= PH_IDLE;
                                done_q <= 1'b1;
                            end
                        endcase
                    end
                    default: ph_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign run        = (ph_q != PH_IDLE);
    assign scl_o      = scl_q;
    assign sda_pull_o = pull_q;
    assign ack_o      = ack_q;
    assign done_o     = done_q;

    // R1: idle leaves both lines released
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE) |-> (scl_q && !pull_q));
    // R4: data bits never move while the clock line is high
    a_r4_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_BIT && scl_q && $past(scl_q)) |-> $stable(pull_q));
    // R5: flags move only in an acknowledge slot or at the start of a transfer
    a_r5_ack_only_in_slot: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ack_q) && ph_q == PH_BIT) |-> (pos_q.bit_idx == 4'd8));
    // R7: done is a single-cycle pulse that follows the stop slot
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r7_done_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> ($past(ph_q) == PH_STOP && ph_q == PH_IDLE));
    // R8: latched word cannot change while a transfer runs
    a_r8_word_hold: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |-> $stable(word_q));
    // R9: a fresh transfer starts with all flags clear
    a_r9_ack_clear: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_START) |-> (ack_q == 3'b000));

endmodule

// File: rtl/i2c_codec_writer.sv
module i2c_codec_writer #(
    parameter int unsigned QTR_CYCLES = i2cw_pkg::QTR_CYCLES_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en_i,
    input  logic [15:0] word_i,
    input  logic        sda_i,
    output logic        scl_o,
    output logic        sda_pull_o,
    output logic [2:0]  ack_o,
    output logic        busy_o,
    output logic        done_o
);
    logic run;
    logic qtick;

    i2cw_quarter_timer #(.QTR_CYCLES(QTR_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .qtick (qtick)
    );

    i2cw_frame_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .qtick      (qtick),
        .wr_en_i    (wr_en_i),
        .word_i     (word_i),
        .sda_i      (sda_i),
        .run        (run),
        .scl_o      (scl_o),
        .sda_pull_o (sda_pull_o),
        .ack_o      (ack_o),
        .done_o     (done_o)
    );

    assign busy_o = run;

    // R8: busy stays up until the done pulse
    a_r8_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

endmodule

// File: tb/i2c_codec_writer_bench.sv
`timescale 1ns/100ps
module i2c_codec_writer_bench;
    localparam int QTR = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] word = 16'h0000;
    bit          slave_pull = 1'b0;
    logic        scl, pull, busy, done;
    logic [2:0]  ack;
    logic        sda_line;

    assign sda_line = !(pull | slave_pull);

    i2c_codec_writer #(.QTR_CYCLES(QTR)) u_i2c_codec_writer (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .word_i(word), .sda_i(sda_line),
        .scl_o(scl), .sda_pull_o(pull), .ack_o(ack), .busy_o(busy), .done_o(done)
    );

    always #2.5 clk = !clk;

    typedef struct { bit scl; bit oe; bit pl; bit busy; bit done; } exp_t;
    exp_t exq[$];

    int tests = 0, fails = 0;
    int scl_err = 0, oe_err = 0, ctl_err = 0, done_cnt = 0;
    bit finished = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one quarter of a slot, expanded to per-clock expectations
    task automatic push_qtr(bit s, bit o, bit p);
        for (int i = 0; i < QTR; i++) exq.push_back('{s, o, p, 1'b1, 1'b0});
    endtask

    // behavioural frame model: slave acks given per byte
    task automatic build(logic [15:0] w, bit [2:0] sack);
        bit [7:0] bytes [3];
        bit prev;
        bytes[0] = 8'h34; bytes[1] = w[15:8]; bytes[2] = w[7:0];
        push_qtr(1, 0, 0); push_qtr(1, 0, 0); push_qtr(1, 1, 0); push_qtr(1, 1, 0);
        prev = 1'b1;
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 9; b++) begin
                bit o;
                bit p;
                o = (b < 8) ? !bytes[k][7-b] : 1'b0;
                p = (b == 8) && sack[k];
                push_qtr(0, prev, 0); push_qtr(0, o, p); push_qtr(1, o, p); push_qtr(1, o, p);
                prev = o;
            end
            if (!sack[k]) break;
        end
        push_qtr(0, prev, 0); push_qtr(0, 1, 0); push_qtr(1, 1, 0); push_qtr(1, 0, 0);
        exq.push_back('{1'b1, 1'b0, 1'b0, 1'b0, 1'b1});
    endtask

    // per-clock comparison, away from the active edge
    always @(posedge clk) begin
        #2;
        if (rst) begin
            slave_pull = 1'b0;
        end else begin
            exp_t e;
            if (exq.size() > 0) e = exq.pop_front();
            else e = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
            slave_pull = e.pl;
            if (done) done_cnt++;
            if (scl !== e.scl) begin
                if (scl_err == 0) $display("  scl mismatch at %0t got %b want %b", $time, scl, e.scl);
                scl_err++;
            end
            if (pull !== e.oe) begin
                if (oe_err == 0) $display("  sda mismatch at %0t got %b want %b", $time, pull, e.oe);
                oe_err++;
            end
            if (busy !== e.busy || done !== e.done) begin
                if (ctl_err == 0) $display("  busy/done mismatch at %0t got %b%b want %b%b",
                                           $time, busy, done, e.busy, e.done);
                ctl_err++;
            end
        end
    end

    task automatic start_xfer(logic [15:0] w, bit [2:0] sack);
        @(negedge clk);
        scl_err = 0; oe_err = 0; ctl_err = 0; done_cnt = 0;
        build(w, sack);
        word  = w;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        word  = 16'h0000;
    endtask

    task automatic finish_xfer(string name, bit [2:0] exp_ack);
        while (exq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk({"R2 scl timing ", name}, scl_err, 0);
        chk({"R3 R4 R6 sda pattern ", name}, oe_err, 0);
        chk({"R7 busy/done sequence ", name}, ctl_err, 0);
        chk({"R7 single done pulse ", name}, done_cnt, 1);
        chk({"R5 ack flags ", name}, ack, exp_ack);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: state in reset
        chk("R1 scl in reset", scl, 1);
        chk("R1 sda in reset", pull, 0);
        chk("R1 busy in reset", busy, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 idle lines after reset", {scl, pull, busy, done, ack}, 7'b1000000);

        // full write of the typical codec word
        start_xfer(16'h080D, 3'b111);
        finish_xfer("t1 080D", 3'b111);

        // refused acknowledge on the lower byte (R6)
        start_xfer(16'hA5C3, 3'b011);
        finish_xfer("t2 A5C3 nack lower", 3'b011);

        // flags clear on start (R9) and strobe ignored while busy (R8)
        start_xfer(16'hFFFF, 3'b111);
        repeat (10) @(negedge clk);
        chk("R9 flags cleared at start", ack, 3'b000);
        repeat (700) @(negedge clk);
        word = 16'h0000; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        finish_xfer("t3 FFFF with R8 strobe", 3'b111);
        chk("R8 no extra transfer", {busy, scl, pull}, 3'b010);

        // refused acknowledge on the address byte (R6)
        start_xfer(16'h1234, 3'b000);
        finish_xfer("t4 nack address", 3'b000);

        // refused acknowledge on the upper byte (R6)
        start_xfer(16'h00FF, 3'b001);
        finish_xfer("t5 nack upper", 3'b001);

        // reset during a transfer (R1)
        start_xfer(16'h5555, 3'b111);
        repeat (500) @(negedge clk);
        rst = 1'b1;
        exq.delete();
        @(negedge clk);
        @(negedge clk);
        chk("R1 lines released by mid-frame reset", {scl, pull, busy, ack}, 6'b100000);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // recovery after reset
        start_xfer(16'h6B9E, 3'b111);
        finish_xfer("t7 6B9E after reset", 3'b111);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule